// File: doc/BRIEF.md
# In-Band Interrupt Receive Queue

This block sits between a byte-stream link from a remote bus target and a host that drains interrupt records. The target sends an interrupt request as a framed byte sequence. The block parses the frame and decides whether the whole record fits in its word queue. It stores the record, or drops it, and answers with a single reply byte. Each stored record is one status word followed by the payload packed four bytes per word. The host pops words one at a time through a single read port. The status word always comes out first.

The block always reports two values. The first is the number of 32-bit words held in the queue. The second is the number of status words not yet read, which is the number of whole records waiting.

Request frames are parsed by a six-state machine:
- `ST_IDLE` waits for the request opcode.
- `ST_ADDR` takes the target address.
- `ST_RNW` takes the direction byte.
- `ST_LEN` collects four length bytes.
- `ST_DATA` collects the payload.
- `ST_REPLY` drives the reply byte for one cycle.

The transitions are:
- IDLE to ADDR when the opcode arrives.
- ADDR to RNW, and RNW to LEN, on any byte.
- LEN to DATA on the fourth length byte when the length is non-zero.
- LEN to REPLY on the fourth length byte when the length is zero.
- DATA to REPLY on the last payload byte.
- REPLY to IDLE always.

Top module: `ibiq_top`

## Requirements
- R1: A request is the opcode byte 0xA1, then an address byte (bits 6:0 used), then a direction byte (bit 0 used), then a 32-bit payload length sent least significant byte first, then the payload bytes. Any byte other than 0xA1 that arrives while the parser is idle is ignored.
- R2: Accepting the final byte of a request (the last length byte when the length is zero) puts the reply on `tx_valid` for exactly one cycle, starting in the cycle after that byte's edge. The reply byte is 0xC0 when the record was stored.
- R3: The status word of a record has the layout {4'h0 receive status, 12'h0, address[6:0], direction, length[7:0]}. It is written at the edge of the last length byte.
- R4: Payload byte k goes into bits 8*(k mod 4)+7 down to 8*(k mod 4) of payload word k/4. A length that is not a multiple of 4 gives one extra word with its unused upper bytes set to zero. Each payload word is written at the edge of its fourth byte or of the last payload byte.
- R5: `ibi_level` equals the number of words held. A push adds one at the write edge, and a read pop removes one.
- R6: `ibi_entries` goes up by one when a status word is written and down by one when a status word is popped.
- R7: A record needs 1 + ceil(length/4) words. When that is more than the free space at the last length byte, or the length is above 255, the reply is 0xC1, the payload is consumed and nothing is stored.
- R8: A read while the queue is empty changes nothing. While the queue is empty, `rd_data` shows zero.
- R9: The word count never exceeds QDEPTH. A record is never partly stored.
- R10: After reset the queue is empty, both counts are zero, `tx_valid` is low and the parser is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Incoming stream byte strobe |
| rx_byte | input | 8 | Incoming stream byte |
| tx_valid | output | 1 | Reply byte strobe |
| tx_byte | output | 8 | Reply byte (0xC0 stored, 0xC1 refused) |
| rd_en | input | 1 | Pop the word at the head of the queue |
| rd_data | output | 32 | Head word of the queue (zero when empty) |
| ibi_level | output | 8 | Words held in the queue |
| ibi_entries | output | 5 | Unread status words |

## Verification
The assertions assume the sender waits for the reply before it starts a new frame, because a byte that arrives during `ST_REPLY` is not parsed. They also assume QDEPTH is at most 31, so the record count fits its port. The stimulus keeps to both assumptions: the default depth is 16, and every frame ends with idle cycles that cover the reply. Within those limits, the stimulus varies:
- back-to-back and gapped bytes;
- reads issued in the same cycles as a status push and a payload push while the queue is empty;
- frames that fill the queue exactly;
- frames refused for lack of room;
- a frame refused for its length.

// File: rtl/ibiq_pkg.sv
package ibiq_pkg;

    localparam logic [7:0] OP_IBI_REQ = 8'hA1;
    localparam logic [7:0] RPL_STORED = 8'hC0;
    localparam logic [7:0] RPL_REFUSE = 8'hC1;
    localparam logic [3:0] RX_STAT_OK = 4'h0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RNW,
        ST_LEN,
        ST_DATA,
        ST_REPLY
    } pst_t;

    function automatic logic [31:0] ibiq_status(input logic [6:0] addr,
                                                input logic       rnw,
                                                input logic [7:0] nbytes);
        return {RX_STAT_OK, 12'd0, addr, rnw, nbytes};
    endfunction

endpackage

// File: rtl/ibiq_word_fifo.sv
module ibiq_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 33,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] cnt_q;
    logic          pop_ok;

    assign pop_ok = pop && (cnt_q != '0);
    assign head   = mem[rd_ptr];
    assign level  = cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            cnt_q <= cnt_q + LW'(push) - LW'(pop_ok);
        end
    end

    // R9: a push without a pop never lands on a full queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (level < LW'(DEPTH)));

    // R8: popping an empty queue leaves it empty
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> (level == '0));

endmodule

// File: rtl/ibiq_msg_parser.sv
module ibiq_msg_parser
    import ibiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic [LW-1:0] q_level,
    output logic          push,
    output logic [31:0]   push_word,
    output logic          push_is_status,
    output logic          tx_valid,
    output logic [7:0]    tx_byte
);
    localparam int CW = 10;

    pst_t        state_q, state_d;
    logic [6:0]  addr_q;
    logic        rnw_q;
    logic [31:0] len_q;
    logic [1:0]  lidx_q;
    logic [31:0] bcnt_q;
    logic [31:0] word_q;
    logic        ok_q;

    logic [31:0]   len_full;
    logic [CW-1:0] need, room;
    logic          fits, len_done, last_byte, word_done;
    logic [1:0]    lane;
    logic [31:0]   word_nx;

    assign len_full  = {rx_byte, len_q[23:0]};
    assign len_done  = (state_q == ST_LEN) && rx_valid && (lidx_q == 2'd3);
    assign need      = CW'(1) + ((CW'(len_full[7:0]) + CW'(3)) >> 2);
    assign room      = CW'(DEPTH) - CW'(q_level);
    assign fits      = (len_full[31:8] == 24'd0) && (need <= room);
    assign lane      = bcnt_q[1:0];
    assign word_nx   = word_q | (32'(rx_byte) << {lane, 3'b000});
    assign last_byte = ((bcnt_q + 32'd1) == len_q);
    assign word_done = (state_q == ST_DATA) && rx_valid && ((lane == 2'd3) || last_byte);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rx_valid && rx_byte == OP_IBI_REQ) state_d = ST_ADDR;
            ST_ADDR:  if (rx_valid) state_d = ST_RNW;
            ST_RNW:   if (rx_valid) state_d = ST_LEN;
            ST_LEN:   if (len_done) state_d = (len_full == 32'd0) ? ST_REPLY : ST_DATA;
            ST_DATA:  if (rx_valid && last_byte) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push           = 1'b0;
        push_word      = 32'd0;
        push_is_status = 1'b0;
        if (len_done && fits) begin
            push           = 1'b1;
            push_word      = ibiq_status(addr_q, rnw_q, len_full[7:0]);
            push_is_status = 1'b1;
        end else if (word_done && ok_q) begin
            push      = 1'b1;
            push_word = word_nx;
        end
        tx_valid = (state_q == ST_REPLY);
        tx_byte  = ok_q ? RPL_STORED : RPL_REFUSE;
    end

    // frame fields and payload packing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rnw_q  <= 1'b0;
            len_q  <= '0;
            lidx_q <= '0;
            bcnt_q <= '0;
            word_q <= '0;
            ok_q   <= 1'b0;
        end else if (rx_valid) begin
            if (state_q == ST_ADDR) addr_q <= rx_byte[6:0];
            if (state_q == ST_RNW) begin
                rnw_q  <= rx_byte[0];
                len_q  <= '0;
                lidx_q <= '0;
            end
            if (state_q == ST_LEN) begin
                if (lidx_q == 2'd3) begin
                    len_q  <= len_full;
                    ok_q   <= fits;
                    bcnt_q <= '0;
                    word_q <= '0;
                end else begin
                    len_q[{lidx_q, 3'b000} +: 8] <= rx_byte;
                    lidx_q <= lidx_q + 2'd1;
                end
            end
            if (state_q == ST_DATA) begin
                bcnt_q <= bcnt_q + 32'd1;
                word_q <= word_done ? 32'd0 : word_nx;
            end
        end
    end

    // R2: the reply strobe lasts one cycle
    assert_reply_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R7: nothing is stored while a refused frame drains
    assert_refused_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !ok_q) |-> !push);

endmodule

// File: rtl/ibiq_top.sv
module ibiq_top
    import ibiq_pkg::*;
#(
    parameter int QDEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic [7:0]  ibi_level,
    output logic [4:0]  ibi_entries
);
    localparam int LW = $clog2(QDEPTH + 1);

    logic          push, push_is_status;
    logic [31:0]   push_word;
    logic [32:0]   head;
    logic [LW-1:0] level;
    logic [LW-1:0] ent_q;
    logic          pop_ok;

    ibiq_msg_parser #(.DEPTH(QDEPTH), .LW(LW)) u_parser (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_valid       (rx_valid),
        .rx_byte        (rx_byte),
        .q_level        (level),
        .push           (push),
        .push_word      (push_word),
        .push_is_status (push_is_status),
        .tx_valid       (tx_valid),
        .tx_byte        (tx_byte)
    );

    ibiq_word_fifo #(.DEPTH(QDEPTH), .W(33), .LW(LW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({push_is_status, push_word}),
        .pop   (rd_en),
        .head  (head),
        .level (level)
    );

    assign pop_ok = rd_en && (level != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_q + LW'(push && push_is_status) - LW'(pop_ok && head[32]);
    end

    assign rd_data     = (level != '0) ? head[31:0] : 32'd0;
    assign ibi_level   = 8'(level);
    assign ibi_entries = 5'(ent_q);

    // R6: unread records never outnumber held words
    assert_entries_le_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ent_q <= level);

    // R8: an empty queue presents zero on the read port
    assert_empty_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ibi_level == 8'd0) |-> (rd_data == 32'd0));

endmodule

// File: tb/ibiq_top_tb.sv
`timescale 1ns/1ps
module ibiq_top_tb;
    localparam int DEPTH = 16;
    localparam logic [7:0] OP  = 8'hA1;
    localparam logic [7:0] ACK = 8'hC0;
    localparam logic [7:0] NAK = 8'hC1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'd0;
    logic        rd_en = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [31:0] rd_data;
    logic [7:0]  ibi_level;
    logic [4:0]  ibi_entries;

    always #2 clk = ~clk;

    ibiq_top #(.QDEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rd_en(rd_en), .rd_data(rd_data),
        .ibi_level(ibi_level), .ibi_entries(ibi_entries)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;
    logic [7:0] last_tx = 8'h00;

    // behavioural reference
    logic [32:0] mq[$];
    int          ms = 0;
    logic [6:0]  m_addr;
    logic        m_rnw;
    longint      m_len;
    int          m_li, m_bc;
    logic [31:0] m_word;
    bit          m_ok = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_entries();
        int n = 0;
        foreach (mq[i]) if (mq[i][32]) n++;
        return n;
    endfunction

    task automatic model_step(input bit v, input logic [7:0] b, input bit rd);
        int pre = mq.size();
        bit p = 0;
        logic [32:0] pw = '0;
        case (ms)
            0: if (v && b == OP) ms = 1;
            1: if (v) begin m_addr = b[6:0]; ms = 2; end
            2: if (v) begin m_rnw = b[0]; ms = 3; m_li = 0; m_len = 0; end
            3: if (v) begin
                m_len = m_len + (longint'(b) << (8 * m_li));
                if (m_li == 3) begin
                    m_ok = (m_len <= 255) && ((1 + (m_len + 3) / 4) <= (DEPTH - pre));
                    if (m_ok) begin
                        p = 1;
                        pw = {1'b1, 4'h0, 12'h0, m_addr, m_rnw, 8'(m_len)};
                    end
                    m_bc = 0; m_word = 0;
                    ms = (m_len == 0) ? 5 : 4;
                end else m_li++;
            end
            4: if (v) begin
                m_word = m_word | (32'(b) << (8 * (m_bc % 4)));
                m_bc++;
                if ((m_bc % 4 == 0) || (m_bc == m_len)) begin
                    if (m_ok) begin p = 1; pw = {1'b0, m_word}; end
                    m_word = 0;
                end
                if (m_bc == m_len) ms = 5;
            end
            5: ms = 0;
            default: ms = 0;
        endcase
        if (rd && pre > 0) void'(mq.pop_front());
        if (p) mq.push_back(pw);
    endtask

    task automatic compare();
        logic [31:0] exp_head;
        exp_head = (mq.size() > 0) ? mq[0][31:0] : 32'd0;
        chk("R2 reply strobe", 32'(tx_valid), 32'(ms == 5));
        if (ms == 5) chk("R2/R7 reply code", 32'(tx_byte), 32'(m_ok ? ACK : NAK));
        if (tx_valid) last_tx = tx_byte;
        chk("R5 level", 32'(ibi_level), 32'(mq.size()));
        chk("R6 entries", 32'(ibi_entries), 32'(m_entries()));
        chk("R3/R4 read data", rd_data, exp_head);
    endtask

    task automatic cyc(input bit v, input logic [7:0] b, input bit rd);
        @(negedge clk);
        compare();
        rx_valid = v; rx_byte = b; rd_en = rd;
        model_step(v, b, rd);
    endtask

    task automatic send(input logic [7:0] addr, input bit rnw, input int len,
                        input logic [7:0] base, input bit gap, input bit rdmix);
        int n = 7 + len;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            if (i == 0) b = OP;
            else if (i == 1) b = addr;
            else if (i == 2) b = {7'd0, rnw};
            else if (i < 7) b = 8'(len >> (8 * (i - 3)));
            else b = 8'(base + (i - 7) * 7);
            cyc(1'b1, b, rdmix && (i % 2 == 0));
            if (gap) cyc(1'b0, 8'd0, 1'b0);
        end
        cyc(1'b0, 8'd0, 1'b0);
        cyc(1'b0, 8'd0, 1'b0);
    endtask

    task automatic pop_expect(input string tag, input logic [31:0] exp);
        cyc(1'b0, 8'd0, 1'b0);
        chk(tag, rd_data, exp);
        cyc(1'b0, 8'd0, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 level", 32'(ibi_level), 0);
        chk("R10 entries", 32'(ibi_entries), 0);
        chk("R10 tx_valid", 32'(tx_valid), 0);
        chk("R10 rd_data", rd_data, 0);
        rst_n = 1'b1;
        cyc(1'b0, 8'd0, 1'b0);

        // R1 stray bytes while idle
        cyc(1'b1, 8'h55, 1'b0);
        cyc(1'b1, 8'hC0, 1'b0);
        cyc(1'b1, 8'h00, 1'b0);
        cyc(1'b0, 8'd0, 1'b0);
        chk("R1 stray bytes ignored", 32'(ibi_level), 0);

        // R1 R2 R3 R4 four-byte payload
        send(8'h10, 1'b0, 4, 8'h11, 1'b0, 1'b0);
        chk("R2 stored reply", 32'(last_tx), 32'(ACK));
        chk("R5 level after record", 32'(ibi_level), 2);
        chk("R6 one record", 32'(ibi_entries), 1);
        pop_expect("R3 status word", 32'h0000_2004);
        pop_expect("R4 payload word", 32'h261F_1811);
        cyc(1'b0, 8'd0, 1'b0);
        chk("R6 drained", 32'(ibi_entries), 0);

        // R4 padding, gapped bytes, direction bit set
        send(8'h2A, 1'b1, 6, 8'h40, 1'b1, 1'b0);
        chk("R5 padded level", 32'(ibi_level), 3);
        pop_expect("R3 status with rnw", 32'h0000_5506);
        pop_expect("R4 first word", 32'h554E_4740);
        pop_expect("R4 padded word", 32'h0000_635C);

        // zero-length record
        send(8'h7F, 1'b0, 0, 8'h00, 1'b0, 1'b0);
        chk("R2 zero length reply", 32'(last_tx), 32'(ACK));
        chk("R5 zero length level", 32'(ibi_level), 1);
        pop_expect("R3 zero length status", 32'h0000_FE00);

        // R8 read while empty
        cyc(1'b0, 8'd0, 1'b1);
        cyc(1'b0, 8'd0, 1'b0);
        chk("R8 empty level", 32'(ibi_level), 0);
        chk("R8 empty data", rd_data, 0);

        // R7 R9 fill and refuse
        send(8'h01, 1'b0, 16, 8'h03, 1'b0, 1'b0);
        send(8'h02, 1'b0, 16, 8'h13, 1'b0, 1'b0);
        send(8'h03, 1'b0, 16, 8'h23, 1'b0, 1'b0);
        chk("R5 fifteen words", 32'(ibi_level), 15);
        send(8'h04, 1'b0, 1, 8'h33, 1'b0, 1'b0);
        chk("R7 refused reply", 32'(last_tx), 32'(NAK));
        chk("R7 nothing stored", 32'(ibi_level), 15);
        chk("R7 entries unchanged", 32'(ibi_entries), 3);
        send(8'h05, 1'b0, 0, 8'h00, 1'b0, 1'b0);
        chk("R9 exact fill", 32'(ibi_level), 16);
        send(8'h06, 1'b0, 300, 8'h44, 1'b0, 1'b0);
        chk("R7 long refused", 32'(last_tx), 32'(NAK));
        chk("R9 no overflow", 32'(ibi_level), 16);
        for (int i = 0; i < 16; i++) cyc(1'b0, 8'd0, 1'b1);
        cyc(1'b0, 8'd0, 1'b0);
        chk("R5 drained", 32'(ibi_level), 0);
        chk("R6 drained all", 32'(ibi_entries), 0);

        // R5 R6 R8 reads overlapping pushes
        send(8'h09, 1'b0, 8, 8'h50, 1'b0, 1'b0);
        send(8'h0A, 1'b0, 4, 8'h60, 1'b0, 1'b1);
        chk("R5 overlap level", 32'(ibi_level), 1);
        chk("R6 overlap entries", 32'(ibi_entries), 0);
        cyc(1'b0, 8'd0, 1'b1);
        cyc(1'b0, 8'd0, 1'b0);
        cyc(1'b0, 8'd0, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule